// File: doc/BRIEF.md
# Grouped interrupt cause and mask controller

This block is a single interrupt group with 32 sources. Each source has a sticky cause bit. Hardware events set these bits, and software can also set them through an injection address. A mask register gates cause bits onto the group interrupt line. A second mask, used for aborts, selects which cause bits raise an abort request towards an attached DMA engine.

Software reaches the group through a plain 32-bit register port: address, write strobe, write data and registered read data. Clearing a cause bit and unmasking a source both use write-zero-acts semantics. Software can therefore acknowledge or enable chosen bits without a read-modify-write.

Delivery on the interrupt line is throttled by a moderation timer. Its length is programmed as an interval times a resolution step. A self-clearing flush bit in the control register releases any held interrupt at once.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset all cause bits are 0, the mask reads 0xFFFFFFFF (every source masked), and the abort mask and control register read 0. `irq_out` and `abort_req` are 0.
- R2: A write to address 0 (cause) clears every cause bit written as 0 and leaves every bit written as 1 unchanged. A read of address 0 returns the cause bits.
- R3: A write to address 1 (cause inject) sets every cause bit written as 1. Address 1 reads as 0.
- R4: Address 2 holds the mask, where a bit value of 1 means masked. It is written directly and reads back the written value.
- R5: A write to address 3 (unmask alias) clears every mask bit written as 0 and leaves bits written as 1 unchanged. Address 3 reads as 0.
- R6: A high bit of `evt_in` sets the matching cause bit at the next clock edge. An event wins over a same-cycle software clear of that bit.
- R7: When an unmasked cause bit is set and the moderation timer is idle, `irq_out` is high one cycle after that register state. With a moderation interval of 0, `irq_out` stays high every cycle while an unmasked cause is set.
- R8: Address 5 (control) holds the resolution in bits [7:0] and the interval in bits [15:8]. After each delivery pulse, no further pulse appears for interval*(resolution+1) cycles. With a cause held pending, pulses are therefore spaced interval*(resolution+1)+1 cycles apart.
- R9: Writing control with bit 16 set releases a pending unmasked interrupt on `irq_out` in the second cycle after the write, whatever the timer state. The flush also restarts the timer from the programmed length, or from zero if nothing is pending. Bit 16 and bits [31:17] read as 0.
- R10: Address 4 holds the abort mask. `abort_req` is high one cycle after any bit of cause AND abort mask is set. It is not affected by the interrupt mask or by moderation.
- R11: Read data is registered: `bus_rdata` shows the register selected by `bus_addr` one cycle later. Unused addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 32 | Hardware event per source, sets cause |
| irq_out | output | 1 | Group interrupt delivery |
| abort_req | output | 1 | Abort request to the DMA engine |

## Verification
The hardest situation to reach is the interaction of the moderation timer with a flush. The timer must be running with a long programmed length while a cause stays pending, and only then may the flush write arrive. The stimulus programs a short period first and measures the spacing between two pulses. It then reprograms the maximum length, waits out one delivery, confirms the line stays quiet, and issues the flush. A collision between an event and a software clear on the same bit is forced directly. The same collision also occurs by chance during a seeded random phase, which checks cause, mask, abort and level interrupt behaviour against a bench model.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CAUSE = 3'd0,
    A_CSET  = 3'd1,
    A_MASK  = 3'd2,
    A_MCLR  = 3'd3,
    A_ABMSK = 3'd4,
    A_CTRL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_grp_regs.sv
module irq_grp_regs
  import irq_grp_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int FLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  wdata,
  input  logic [SRC_W-1:0]  evt_in,
  output logic [SRC_W-1:0]  cause_q,
  output logic [SRC_W-1:0]  mask_q,
  output logic [SRC_W-1:0]  abmask_q,
  output logic [FLD_W-1:0]  res_q,
  output logic [FLD_W-1:0]  intv_q,
  output logic              flush_q
);
  localparam int FLUSH_BIT = 2 * FLD_W;

  logic [SRC_W-1:0] cause_d;

  always_comb begin
    cause_d = cause_q;
    if (wr_en && addr == A_CAUSE) cause_d = cause_d & wdata;
    if (wr_en && addr == A_CSET)  cause_d = cause_d | wdata;
    cause_d = cause_d | evt_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q  <= '0;
      mask_q   <= '1;
      abmask_q <= '0;
      res_q    <= '0;
      intv_q   <= '0;
      flush_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      flush_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_MASK:  mask_q   <= wdata;
          A_MCLR:  mask_q   <= mask_q & wdata;
          A_ABMSK: abmask_q <= wdata;
          A_CTRL: begin
            res_q   <= wdata[FLD_W-1:0];
            intv_q  <= wdata[2*FLD_W-1:FLD_W];
            flush_q <= wdata[FLUSH_BIT];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_grp_moder.sv
module irq_grp_moder #(
  parameter int FLD_W = 8,
  localparam int TMR_W = 2 * FLD_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             flush,
  input  logic [FLD_W-1:0] res,
  input  logic [FLD_W-1:0] intv,
  output logic             irq_out,
  output logic [TMR_W-1:0] timer_q
);
  logic [TMR_W-1:0] load_val;
  logic             idle;
  logic             deliver;

  assign load_val = TMR_W'(intv) * (TMR_W'(res) + TMR_W'(1));
  assign idle     = (timer_q == '0);
  assign deliver  = pending && (idle || flush);

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      irq_out <= 1'b0;
    end else begin
      irq_out <= deliver;
      if (deliver)     timer_q <= load_val;
      else if (flush)  timer_q <= '0;
      else if (!idle)  timer_q <= timer_q - TMR_W'(1);
    end
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int FLD_W = 8,
  localparam int TMR_W = 2 * FLD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic [SRC_W-1:0]  bus_rdata,
  input  logic [SRC_W-1:0]  evt_in,
  output logic              irq_out,
  output logic              abort_req
);
  logic [SRC_W-1:0] cause_q, mask_q, abmask_q;
  logic [FLD_W-1:0] res_q, intv_q;
  logic             flush_q;
  logic [TMR_W-1:0] timer_q;
  logic             pending;
  logic [SRC_W-1:0] rd_mux;

  irq_grp_regs #(.SRC_W(SRC_W), .FLD_W(FLD_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .evt_in(evt_in), .cause_q(cause_q), .mask_q(mask_q), .abmask_q(abmask_q),
    .res_q(res_q), .intv_q(intv_q), .flush_q(flush_q)
  );

  assign pending = |(cause_q & ~mask_q);

  irq_grp_moder #(.FLD_W(FLD_W)) moder_i (
    .clk(clk), .rst(rst), .pending(pending), .flush(flush_q),
    .res(res_q), .intv(intv_q), .irq_out(irq_out), .timer_q(timer_q)
  );

  always_comb begin
    case (bus_addr)
      A_CAUSE: rd_mux = cause_q;
      A_MASK:  rd_mux = mask_q;
      A_ABMSK: rd_mux = abmask_q;
      A_CTRL:  rd_mux = SRC_W'({intv_q, res_q});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      abort_req <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      abort_req <= |(cause_q & abmask_q);
    end
  end
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk #(
  parameter int SRC_W = 32,
  parameter int TMR_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [SRC_W-1:0] evt_in,
  input logic [SRC_W-1:0] cause_q,
  input logic [SRC_W-1:0] mask_q,
  input logic [SRC_W-1:0] abmask_q,
  input logic [TMR_W-1:0] timer_q,
  input logic             flush_q,
  input logic             irq_out,
  input logic             abort_req
);
  assert_evt_sets_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (|evt_in) |=> ((cause_q & $past(evt_in)) == $past(evt_in)));

  assert_unmask_only_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3) |=> ((mask_q & ~$past(mask_q)) == '0));

  assert_irq_needs_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(cause_q & ~mask_q)));

  assert_moder_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_out && timer_q != '0 && !flush_q) |=> !irq_out);

  assert_abort_follows_R10: assert property (@(posedge clk) disable iff (rst)
    abort_req == $past(|(cause_q & abmask_q)));
endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(.SRC_W(SRC_W), .TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .evt_in(evt_in),
  .cause_q(cause_q), .mask_q(mask_q), .abmask_q(abmask_q), .timer_q(timer_q),
  .flush_q(flush_q), .irq_out(irq_out), .abort_req(abort_req)
);

// File: tb/irq_group_ctrl_tb_top.sv
module irq_group_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_in = '0;
  logic        irq_out, abort_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_cause, m_mask, m_ab;

  always #5 clk = ~clk;

  irq_group_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq_out(irq_out), .abort_req(abort_req)
  );

  function automatic logic [31:0] next_cause(logic [31:0] c, logic wr, logic [2:0] a,
                                             logic [31:0] d, logic [31:0] e);
    logic [31:0] r = c;
    if (wr && a == 3'd0) r = r & d;
    if (wr && a == 3'd1) r = r | d;
    return r | e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int p1, p2;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R11 registered read
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    check("R1 abort", {31'b0, abort_req}, 32'h0);
    rd(3'd0, v); check("R1 cause", v, 32'h0);
    rd(3'd2, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R1 abmask", v, 32'h0);
    rd(3'd5, v); check("R1 ctrl", v, 32'h0);
    rd(3'd7, v); check("R11 unused addr", v, 32'h0);

    // R3 inject, R2 write-zero clear
    wr(3'd1, 32'h0000_00FF);
    rd(3'd0, v); check("R3 inject", v, 32'h0000_00FF);
    rd(3'd1, v); check("R3 alias reads 0", v, 32'h0);
    wr(3'd0, 32'hFFFF_FF0F);
    rd(3'd0, v); check("R2 clear zeros", v, 32'h0000_000F);

    // R4 mask, R5 unmask alias
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, v); check("R4 mask rw", v, 32'h1234_5678);
    wr(3'd3, ~32'h0000_0008);
    rd(3'd2, v); check("R5 unmask", v, 32'h1234_5670);
    rd(3'd3, v); check("R5 alias reads 0", v, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 masked cause gives nothing; unmask raises level
    @(negedge clk);
    check("R7 masked no irq", {31'b0, irq_out}, 32'h0);
    wr(3'd3, ~32'h0000_0001);
    check("R7 not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R7 irq up", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R7 level held", {31'b0, irq_out}, 32'h1);
    wr(3'd0, 32'h0);
    @(negedge clk);
    check("R7 irq drops", {31'b0, irq_out}, 32'h0);

    // R6 event beats same-cycle clear
    wr(3'd1, 32'h0000_0030);
    @(negedge clk);
    bus_addr = 3'd0; bus_wr = 1'b1; bus_wdata = 32'h0; evt_in = 32'h0000_0020;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    rd(3'd0, v); check("R6 event wins", v, 32'h0000_0020);

    // R10 abort independent of mask
    wr(3'd4, 32'h0000_0020);
    check("R10 abort lag", {31'b0, abort_req}, 32'h0);
    @(negedge clk);
    check("R10 abort up", {31'b0, abort_req}, 32'h1);
    check("R10 irq still masked", {31'b0, irq_out}, 32'h0);
    wr(3'd0, 32'h0);
    @(negedge clk);
    check("R10 abort down", {31'b0, abort_req}, 32'h0);

    // R8 moderation spacing: res=1 intv=3 -> 6 quiet cycles, spacing 7
    wr(3'd5, 32'h0000_0301);
    rd(3'd5, v); check("R8 ctrl layout", v, 32'h0000_0301);
    wr(3'd1, 32'h0000_0001);
    p1 = -1; p2 = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq_out) begin
        if (p1 < 0) p1 = i;
        else if (p2 < 0) p2 = i;
      end
    end
    check("R8 pulse spacing", 32'(p2 - p1), 32'd7);

    // R9 flush with a long timer
    wr(3'd5, 32'h0000_FFFF);
    repeat (10) @(negedge clk);
    p1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_out) p1++;
    end
    check("R8 long hold quiet", 32'(p1), 32'd0);
    wr(3'd5, 32'h0001_FFFF);
    check("R9 flush lag", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R9 flush delivers", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R9 timer restarted", {31'b0, irq_out}, 32'h0);
    rd(3'd5, v); check("R9 flush bit reads 0", v, 32'h0000_FFFF);
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h0001_0000);
    wr(3'd1, 32'h0000_0001);
    @(negedge clk);
    check("R9 timer cleared", {31'b0, irq_out}, 32'h1);

    // Random phase, interval 0
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd4, 32'h0);
    m_cause = 32'h0; m_mask = 32'hFFFF_FFFF; m_ab = 32'h0;
    for (int s = 0; s < 400; s++) begin
      logic [2:0]  a;
      logic [31:0] d, e;
      logic        w;
      a = 3'($urandom_range(0, 4));
      d = $urandom();
      if (a == 3'd1 || a == 3'd2 || a == 3'd4) d = d & $urandom() & $urandom();
      if (a == 3'd0 || a == 3'd3) d = d | $urandom() | $urandom();
      e = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : 32'h0;
      w = ($urandom_range(0, 4) != 0);
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_wdata = d; evt_in = e;
      @(negedge clk);
      bus_wr = 1'b0; evt_in = '0;
      m_cause = next_cause(m_cause, w, a, d, e);
      if (w && a == 3'd2) m_mask = d;
      if (w && a == 3'd3) m_mask = m_mask & d;
      if (w && a == 3'd4) m_ab = d;
      if (s % 8 == 7) begin
        rd(3'd0, v); check("R2 R3 R6 random cause", v, m_cause);
        rd(3'd2, v); check("R4 R5 random mask", v, m_mask);
        check("R10 random abort", {31'b0, abort_req}, {31'b0, |(m_cause & m_ab)});
        check("R7 random irq", {31'b0, irq_out}, {31'b0, |(m_cause & ~m_mask)});
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule